// File: doc/BRIEF.md
# Accumulator ALU with condition flags

This block is the arithmetic-logic stage of an 8-bit accumulator processor. Each cycle it takes an operation code, an accumulator operand and a memory operand, both 16 bits wide, plus the incoming condition-code byte. One clock later it presents the result and the updated condition-code byte. Byte operations use the low byte of each operand. The three double-byte operations treat the whole accumulator operand as the D pair and the whole memory operand as a two-byte value.

Each operation follows its own flag rule. A flag is either computed, forced to a fixed value, or carried over from the incoming byte. Half carry is produced only by the byte add forms. The operation codes are those of the package enumeration, numbered 0 to 22 in this order: ADD, ADC, SUB, SBC, CMP, AND, OR, EOR, BIT, COM, NEG, INC, DEC, CLR, ASL, ASR, LSR, ROL, ROR, DAA, ADDD, SUBD, CMPD. ASL also serves as the logical left shift.

Top module: `acc_alu`

## Requirements
- R1: Synchronous active-high reset drives res_o and cc_o to zero. Otherwise both outputs are registered and reflect the inputs of the previous clock edge.
- R2: ADD forms a+m and ADC forms a+m+C. The result is the low 8 bits. C is the carry out of bit 7 and H is the carry out of bit 3. V is set when the operands share a sign and the result sign differs. N and Z follow the result.
- R3: SUB forms a-m, SBC forms a-m-C and CMP forms a-m. C is the borrow. V is set when the operands differ in sign and the result sign differs from a. N and Z follow the difference and H is kept. CMP returns a unchanged in res_o[7:0].
- R4: AND, OR and EOR return the bitwise result. BIT tests a AND m but returns a. All four set N and Z from the bitwise value, clear V, and keep C and H.
- R5: COM returns ~a with V=0 and C=1. NEG returns 0-a with C set when a is nonzero and V set when a is 0x80.
- R6: INC and DEC return a+1 and a-1 modulo 256. V is set for a=0x7F (INC) or a=0x80 (DEC). C and H are kept.
- R7: CLR returns 0 with Z=1 and N=V=C=0.
- R8: ASL shifts in 0 and ROL shifts in the old C, both at bit 0. C takes the old bit 7. V equals N XOR C of the new flags.
- R9: ASR keeps bit 7, LSR shifts in 0 and ROR shifts in the old C, each at bit 7. C takes the old bit 0. V is kept and N, Z follow the result.
- R10: DAA adds 0x06 when H is set or the low digit exceeds 9. It adds 0x60 when C is set, the high digit exceeds 9, or the high digit exceeds 8 while the low digit exceeds 9. C becomes old C OR the upper correction, V=0, and N, Z follow the result.
- R11: ADDD and SUBD compute D+M and D-M on 16 bits. CMPD computes D-M but returns D. C is the carry or borrow, V uses the sign rules of R2 and R3 at bit 15, N and Z follow the 16-bit value, and H is kept.
- R12: In the condition-code byte, H is bit 5, N bit 3, Z bit 2, V bit 1 and C bit 0. Bits 7, 6 and 4 always pass through. Byte operations ignore acc_i[15:8] and m_i[15:8] and return 0 in res_o[15:8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 16 | Accumulator operand; low byte for byte operations, D pair for double-byte operations |
| m_i | input | 16 | Memory operand; low byte or two-byte value |
| cc_i | input | 8 | Incoming condition-code byte |
| res_o | output | 16 | Registered result |
| cc_o | output | 8 | Registered updated condition-code byte |

## Verification
The hardest behaviour to reach from the ports is decimal adjust when the incoming H and C disagree with the digits actually in the accumulator. The same applies to the overflow corners of the 16-bit forms, which random 16-bit operands rarely hit. The stimulus runs every accumulator byte through each unary, shift and adjust operation under all four H/C combinations. It pairs every byte with sixteen spread memory bytes for the two-operand forms. For the double-byte forms it mixes pseudo-random pairs with pinned values around 0x7FFF, 0x8000, 0x0000 and 0xFFFF, and keeps random garbage in the ignored upper bytes and spare flag bits throughout.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPW   = 5;
  localparam int H_BIT = 5;
  localparam int N_BIT = 3;
  localparam int Z_BIT = 2;
  localparam int V_BIT = 1;
  localparam int C_BIT = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
    OP_AND, OP_OR, OP_EOR, OP_BIT,
    OP_COM, OP_NEG, OP_INC, OP_DEC, OP_CLR,
    OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR,
    OP_DAA, OP_ADDD, OP_SUBD, OP_CMPD
  } op_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter bit GEN_H = 1'b1,
  parameter int HALF  = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  input  logic         cin,
  input  flags_t       fin,
  output logic [W-1:0] sum,
  output flags_t       fo
);
  logic [W-1:0] yy;
  logic         ci;
  logic         co;
  logic         hc;
  logic [HALF-1:0] nib_unused;

  assign yy = sub ? ~y : y;
  assign ci = sub ? ~cin : cin;
  assign {co, sum} = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, ci};
  assign {hc, nib_unused} = {1'b0, x[HALF-1:0]} + {1'b0, yy[HALF-1:0]} + {{HALF{1'b0}}, ci};

  always_comb begin
    fo   = fin;
    fo.c = sub ? ~co : co;
    fo.v = (x[W-1] == yy[W-1]) && (sum[W-1] != x[W-1]);
    fo.n = sum[W-1];
    fo.z = (sum == '0);
    fo.h = (GEN_H && !sub) ? hc : fin.h;
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  flags_t       fin,
  output logic [W-1:0] r,
  output flags_t       fo
);
  localparam logic [W-1:0] MINV = W'(1) << (W-1);
  localparam logic [W-1:0] MAXP = ~MINV;

  logic [W-1:0] fv;

  always_comb begin
    fo = fin;
    r  = a;
    fv = a;
    case (op)
      OP_AND: begin r = a & m; fv = r; fo.v = 1'b0; end
      OP_OR:  begin r = a | m; fv = r; fo.v = 1'b0; end
      OP_EOR: begin r = a ^ m; fv = r; fo.v = 1'b0; end
      OP_BIT: begin r = a; fv = a & m; fo.v = 1'b0; end
      OP_COM: begin r = ~a; fv = r; fo.v = 1'b0; fo.c = 1'b1; end
      OP_NEG: begin
        r    = '0 - a;
        fv   = r;
        fo.v = (a == MINV);
        fo.c = (a != '0);
      end
      OP_INC: begin r = a + W'(1); fv = r; fo.v = (a == MAXP); end
      OP_DEC: begin r = a - W'(1); fv = r; fo.v = (a == MINV); end
      OP_CLR: begin r = '0; fv = '0; fo.v = 1'b0; fo.c = 1'b0; end
      default: begin r = a; fv = a; end
    endcase
    fo.n = fv[W-1];
    fo.z = (fv == '0);
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  flags_t       fin,
  output logic [W-1:0] r,
  output flags_t       fo
);
  logic left;
  logic fill;

  always_comb begin
    left = (op == OP_ASL) || (op == OP_ROL);
    case (op)
      OP_ROL:  fill = fin.c;
      OP_ASR:  fill = a[W-1];
      OP_ROR:  fill = fin.c;
      default: fill = 1'b0;
    endcase
    if (left) r = {a[W-2:0], fill};
    else      r = {fill, a[W-1:1]};
    fo   = fin;
    fo.c = left ? a[W-1] : a[0];
    fo.n = r[W-1];
    fo.z = (r == '0);
    if (left) fo.v = r[W-1] ^ a[W-1];
  end
endmodule

// File: rtl/acc_alu_daa.sv
module acc_alu_daa
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  flags_t       fin,
  output logic [W-1:0] r,
  output flags_t       fo
);
  localparam int NB = W / 2;
  localparam logic [NB-1:0] NINE  = NB'(9);
  localparam logic [NB-1:0] EIGHT = NB'(8);
  localparam logic [W-1:0]  LOFIX = W'(6);
  localparam logic [W-1:0]  HIFIX = W'(6) << NB;

  logic [NB-1:0] lo_d;
  logic [NB-1:0] hi_d;
  logic          fix_lo;
  logic          fix_hi;

  assign lo_d   = a[NB-1:0];
  assign hi_d   = a[W-1:NB];
  assign fix_lo = fin.h || (lo_d > NINE);
  assign fix_hi = fin.c || (hi_d > NINE) || ((hi_d > EIGHT) && (lo_d > NINE));
  assign r      = a + (fix_lo ? LOFIX : '0) + (fix_hi ? HIFIX : '0);

  always_comb begin
    fo   = fin;
    fo.c = fin.c | fix_hi;
    fo.v = 1'b0;
    fo.n = r[W-1];
    fo.z = (r == '0);
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPW-1:0]    op_i,
  input  logic [2*W-1:0]    acc_i,
  input  logic [2*W-1:0]    m_i,
  input  logic [7:0]        cc_i,
  output logic [2*W-1:0]    res_o,
  output logic [7:0]        cc_o
);
  localparam int WW = 2 * W;

  op_e          op;
  flags_t       fin;
  flags_t       f8, f16, fl_l, fl_s, fl_d, fsel;
  logic [W-1:0] s8, r_l, r_s, r_d;
  logic [WW-1:0] s16;
  logic [WW-1:0] res_d;
  logic [7:0]   cc_d;
  logic         sub8, usec8, sub16;

  assign op  = op_e'(op_i);
  assign fin = '{h: cc_i[H_BIT], n: cc_i[N_BIT], z: cc_i[Z_BIT],
                 v: cc_i[V_BIT], c: cc_i[C_BIT]};

  assign sub8  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign usec8 = (op == OP_ADC) || (op == OP_SBC);
  assign sub16 = (op != OP_ADDD);

  acc_alu_addsub #(.W(W), .GEN_H(1'b1), .HALF(4)) u_add8 (
    .x(acc_i[W-1:0]), .y(m_i[W-1:0]), .sub(sub8), .cin(usec8 & fin.c),
    .fin(fin), .sum(s8), .fo(f8)
  );

  acc_alu_addsub #(.W(WW), .GEN_H(1'b0), .HALF(4)) u_add16 (
    .x(acc_i), .y(m_i), .sub(sub16), .cin(1'b0),
    .fin(fin), .sum(s16), .fo(f16)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op(op), .a(acc_i[W-1:0]), .m(m_i[W-1:0]), .fin(fin), .r(r_l), .fo(fl_l)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .op(op), .a(acc_i[W-1:0]), .fin(fin), .r(r_s), .fo(fl_s)
  );

  acc_alu_daa #(.W(W)) u_daa (
    .a(acc_i[W-1:0]), .fin(fin), .r(r_d), .fo(fl_d)
  );

  always_comb begin
    res_d = '0;
    fsel  = fin;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin res_d = {{W{1'b0}}, s8}; fsel = f8; end
      OP_CMP: begin res_d = {{W{1'b0}}, acc_i[W-1:0]}; fsel = f8; end
      OP_AND, OP_OR, OP_EOR, OP_BIT, OP_COM, OP_NEG, OP_INC, OP_DEC, OP_CLR: begin
        res_d = {{W{1'b0}}, r_l};
        fsel  = fl_l;
      end
      OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
        res_d = {{W{1'b0}}, r_s};
        fsel  = fl_s;
      end
      OP_DAA: begin res_d = {{W{1'b0}}, r_d}; fsel = fl_d; end
      OP_ADDD, OP_SUBD: begin res_d = s16; fsel = f16; end
      OP_CMPD: begin res_d = acc_i; fsel = f16; end
      default: begin res_d = '0; fsel = fin; end
    endcase
    cc_d        = cc_i;
    cc_d[H_BIT] = fsel.h;
    cc_d[N_BIT] = fsel.n;
    cc_d[Z_BIT] = fsel.z;
    cc_d[V_BIT] = fsel.v;
    cc_d[C_BIT] = fsel.c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      cc_o  <= '0;
    end else begin
      res_o <= res_d;
      cc_o  <= cc_d;
    end
  end

  // Operation classes observed by the checks below
  logic k_subany, k_logic, k_incdec, k_left, k_lsr, k_com, k_clr, k_cmpd;
  assign k_subany = sub8 || (op == OP_SUBD) || (op == OP_CMPD);
  assign k_logic  = (op == OP_AND) || (op == OP_OR) || (op == OP_EOR) || (op == OP_BIT);
  assign k_incdec = (op == OP_INC) || (op == OP_DEC);
  assign k_left   = (op == OP_ASL) || (op == OP_ROL);
  assign k_lsr    = (op == OP_LSR);
  assign k_com    = (op == OP_COM);
  assign k_clr    = (op == OP_CLR);
  assign k_cmpd   = (op == OP_CMPD);

  a_r12_spare_bits_pass: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cc_o[7] == $past(cc_i[7])) && (cc_o[6] == $past(cc_i[6]))
                    && (cc_o[4] == $past(cc_i[4])));

  a_r3_sub_keeps_h: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(k_subany)) |-> cc_o[H_BIT] == $past(cc_i[H_BIT]));

  a_r4_logic_keeps_c: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(k_logic)) |-> (cc_o[C_BIT] == $past(cc_i[C_BIT])) && !cc_o[V_BIT]);

  a_r5_com_sets_c: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(k_com)) |-> cc_o[C_BIT] && !cc_o[V_BIT]
                                     && (res_o[W-1:0] == ~$past(acc_i[W-1:0])));

  a_r6_incdec_keeps_c: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(k_incdec)) |-> cc_o[C_BIT] == $past(cc_i[C_BIT]));

  a_r7_clear_flags: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(k_clr)) |-> (res_o == '0) && cc_o[Z_BIT] && !cc_o[N_BIT]
                                     && !cc_o[V_BIT] && !cc_o[C_BIT]);

  a_r8_left_v_rule: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(k_left)) |-> cc_o[V_BIT] == (cc_o[N_BIT] ^ cc_o[C_BIT]));

  a_r9_lsr_clears_n: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(k_lsr)) |-> !cc_o[N_BIT] && (cc_o[V_BIT] == $past(cc_i[V_BIT])));

  a_r11_cmpd_returns_d: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(k_cmpd)) |-> res_o == $past(acc_i));
endmodule

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
  import acc_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [15:0] acc_i = '0;
  logic [15:0] m_i = '0;
  logic [7:0]  cc_i = '0;
  logic [15:0] res_o;
  logic [7:0]  cc_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  acc_alu #(.W(8)) dut (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .m_i(m_i),
    .cc_i(cc_i), .res_o(res_o), .cc_o(cc_o)
  );

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic int sx8(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic int sx16(int x);
    return (x >= 32768) ? x - 65536 : x;
  endfunction

  function automatic string tag(op_e op);
    case (op)
      OP_ADD, OP_ADC: return "R2";
      OP_SUB, OP_SBC, OP_CMP: return "R3";
      OP_AND, OP_OR, OP_EOR, OP_BIT: return "R4";
      OP_COM, OP_NEG: return "R5";
      OP_INC, OP_DEC: return "R6";
      OP_CLR: return "R7";
      OP_ASL, OP_ROL: return "R8";
      OP_ASR, OP_LSR, OP_ROR: return "R9";
      OP_DAA: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Expected {res, cc}, from the requirement text
  function automatic logic [23:0] model(op_e op, logic [15:0] d, logic [15:0] mm, logic [7:0] cc);
    int ai, mi, di, wi, s, ss, ci, t, outv, lo, hi, corr;
    bit fh, fn, fz, fv, fc, wide;
    ai = int'(d[7:0]); mi = int'(mm[7:0]);
    di = int'(d); wi = int'(mm);
    fh = cc[5]; fv = cc[1]; fc = cc[0];
    wide = 1'b0; t = 0; outv = 0;
    case (op)
      OP_ADD, OP_ADC: begin
        ci = (op == OP_ADC) ? int'(fc) : 0;
        s  = ai + mi + ci; ss = sx8(ai) + sx8(mi) + ci;
        fh = ((ai % 16) + (mi % 16) + ci) > 15;
        fc = s > 255; fv = (ss > 127) || (ss < -128);
        t = s & 255; outv = t;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        ci = (op == OP_SBC) ? int'(fc) : 0;
        s  = ai - mi - ci; ss = sx8(ai) - sx8(mi) - ci;
        fc = s < 0; fv = (ss > 127) || (ss < -128);
        t = s & 255; outv = (op == OP_CMP) ? ai : t;
      end
      OP_AND: begin t = ai & mi; outv = t; fv = 0; end
      OP_OR:  begin t = ai | mi; outv = t; fv = 0; end
      OP_EOR: begin t = ai ^ mi; outv = t; fv = 0; end
      OP_BIT: begin t = ai & mi; outv = ai; fv = 0; end
      OP_COM: begin t = 255 - ai; outv = t; fv = 0; fc = 1; end
      OP_NEG: begin t = (256 - ai) & 255; outv = t; fv = (ai == 128); fc = (ai != 0); end
      OP_INC: begin t = (ai + 1) & 255; outv = t; fv = (ai == 127); end
      OP_DEC: begin t = (ai + 255) & 255; outv = t; fv = (ai == 128); end
      OP_CLR: begin t = 0; outv = 0; fv = 0; fc = 0; end
      OP_ASL, OP_ROL: begin
        t = (ai * 2 + ((op == OP_ROL) ? int'(fc) : 0)) & 255;
        fc = ai >= 128; fv = (t >= 128) ^ fc; outv = t;
      end
      OP_ASR, OP_LSR, OP_ROR: begin
        t = ai / 2;
        if (op == OP_ASR && ai >= 128) t += 128;
        if (op == OP_ROR && fc) t += 128;
        fc = (ai % 2) == 1; outv = t;
      end
      OP_DAA: begin
        lo = ai % 16; hi = ai / 16; corr = 0;
        if (fh || lo > 9) corr += 6;
        if (fc || hi > 9 || (hi > 8 && lo > 9)) begin corr += 96; fc = 1; end
        t = (ai + corr) & 255; outv = t; fv = 0;
      end
      default: begin
        wide = 1'b1;
        if (op == OP_ADDD) begin
          s = di + wi; ss = sx16(di) + sx16(wi); fc = s > 65535;
        end else begin
          s = di - wi; ss = sx16(di) - sx16(wi); fc = s < 0;
        end
        fv = (ss > 32767) || (ss < -32768);
        t = s & 65535; outv = (op == OP_CMPD) ? di : t;
      end
    endcase
    fn = wide ? (t >= 32768) : (t >= 128);
    fz = (t == 0);
    return {16'(outv), cc[7:6], fh, cc[4], fn, fz, fv, fc};
  endfunction

  task automatic run(op_e op, logic [15:0] d, logic [15:0] mm, logic [7:0] cc);
    logic [23:0] exp;
    op_i = op; acc_i = d; m_i = mm; cc_i = cc;
    exp = model(op, d, mm, cc);
    @(posedge clk); #1;
    checks++;
    if ({res_o, cc_o} !== exp) begin
      failures++;
      $display("FAIL %s op=%0d d=%h m=%h cc=%h actual=%h/%h expected=%h/%h",
               tag(op), op, d, mm, cc, res_o, cc_o, exp[23:8], exp[7:0]);
    end
  endtask

  task automatic note_rst(string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R1 %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    op_e bin_ops [9] = '{OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_AND, OP_OR, OP_EOR, OP_BIT};
    op_e un_ops [11] = '{OP_COM, OP_NEG, OP_INC, OP_DEC, OP_CLR, OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR, OP_DAA};
    op_e w_ops [3]   = '{OP_ADDD, OP_SUBD, OP_CMPD};
    logic [15:0] corner [8] = '{16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF,
                                16'h0001, 16'h8001, 16'h7FFE, 16'h00FF};

    // R1: reset holds outputs at zero even with live inputs
    op_i = OP_COM; acc_i = 16'h00F0; m_i = 16'h1234; cc_i = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    note_rst("reset outputs", {res_o, cc_o}, 24'h0);
    rst = 1'b0;
    // R1: first registered result appears one edge after release
    run(OP_ADD, 16'h0012, 16'h0034, 8'h00);

    // R12: byte ops ignore upper operand bytes (garbage in, zero out)
    run(OP_ADD, 16'hAB01, 16'hCD02, 8'hD0);

    // R2 R3 R4: every accumulator byte against spread memory bytes
    foreach (bin_ops[i]) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 16; k++) begin
          logic [7:0] mb, ccb;
          seed = step(seed);
          mb  = 8'(k * 17 + ((k[0]) ? a : 0));
          ccb = {seed[7:6], 1'(k >> 1), seed[4:2], 1'(k >> 2), 1'(k ^ a)};
          run(bin_ops[i], {seed[15:8], 8'(a)}, {seed[23:16], mb}, ccb);
        end
      end
    end

    // R5..R10: every byte under all four H/C combinations
    foreach (un_ops[i]) begin
      for (int a = 0; a < 256; a++) begin
        for (int hc = 0; hc < 4; hc++) begin
          seed = step(seed);
          run(un_ops[i], {seed[15:8], 8'(a)}, seed[31:16],
              {seed[7:6], 1'(hc >> 1), seed[4:1], 1'(hc)});
        end
      end
    end

    // R11: double-byte forms, pinned corners then pseudo-random pairs
    foreach (w_ops[i]) begin
      foreach (corner[x]) begin
        foreach (corner[y]) begin
          seed = step(seed);
          run(w_ops[i], corner[x], corner[y], seed[7:0]);
        end
      end
      for (int n = 0; n < 4000; n++) begin
        seed = step(seed);
        run(w_ops[i], seed[15:0], seed[31:16], seed[7:0] ^ seed[23:16]);
      end
    end

    // R1: reset again clears registered state
    rst = 1'b1;
    @(posedge clk); #1;
    note_rst("reassert reset", {res_o, cc_o}, 24'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule